// File: doc/BRIEF.md
# Serial Adapter Host Register and Interrupt Interface

This block is the processor-facing side of an asynchronous serial adapter. A host sees two byte-wide registers, chosen by a single register-select input. Reading the first returns a status byte. Writing the first loads the control byte. Reading the second returns the last received character. Writing the second hands a character to the transmitter. Any wider address mirroring is left to the host's decoder, because only the one select bit reaches this block.

The block holds the control byte and drives its fields to the bit engines: clock ratio, word format, modem line levels and break. It captures characters and error qualifiers from the receiver and keeps a transmit holding byte for the transmitter. It also latches changes on the carrier-detect input. From these flags it builds the status byte and one active-low interrupt line.

A flag is cleared only as a side effect of a data-register access or by the control-field master-reset code. No status write exists.

Top module: `serial_host_if`

## Requirements
- R1: An access happens on any clock edge where `chipSel` is 1. `readNotWrite`=1 means read. `regSel`=0 addresses status (read) and control (write). `regSel`=1 addresses receive data (read) and transmit data (write). `dataOut` is 0 whenever no read is in progress.
- R2: The status byte has these bits: bit0 receive full, bit1 transmit empty, bit2 carrier changed, bit3 live level of `ctsIn`, bit4 framing error, bit5 overrun, bit6 parity error, bit7 interrupt active. The byte is returned during the read cycle itself.
- R3: A control write stores the whole byte. Bits 1:0 drive `clockDiv` and bits 4:2 drive `wordFormat`. Bits 6:5 select the line and interrupt mode: 00 gives `rtsN`=0; 01 gives `rtsN`=0 with the transmit interrupt enabled; 10 gives `rtsN`=1; 11 gives `rtsN`=0 with `breakOut`=1.
- R4: While control bits 1:0 are 11, and on the edge that writes 11, the following hold. `masterReset` is 1. Receive full, overrun, framing, parity and carrier-changed flags are cleared. Transmit empty is set. Receive loads, transmit takes, carrier edges and data writes are ignored.
- R5: A `rxLoad` pulse while receive is not full stores `rxByte`, `rxFrameErr` and `rxParityErr` and sets receive full.
- R6: A `rxLoad` pulse while receive is full, with no data read in the same cycle, sets overrun and discards the new byte. The held byte is kept.
- R7: A receive-data read clears receive full, overrun, framing and parity. If `rxLoad` arrives in the same cycle, the new byte is stored without overrun.
- R8: A transmit-data write stores the byte on `txByte` and clears transmit empty (`txValid`=1). A `txTaken` pulse sets transmit empty. If a write and `txTaken` fall in the same cycle, the write wins.
- R9: Any edge on `dcdIn` sets carrier changed. The flag clears only on a receive-data read that follows a status read made while the flag was set. A new edge cancels that earlier status read.
- R10: Status bit 7 is 1 exactly when (control bit 7 is set and any of receive full, overrun or carrier changed is set) or (bits 6:5 are 01 and transmit empty is set). `irqN` is the inverse of status bit 7.
- R11: After `rstN` is released, the control byte is 0, status reads 0x02 with `ctsIn` low, `irqN` is 1 and `txValid` is 0.
- R12: Status reads, and control writes whose bits 1:0 are not 11, leave every latched flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chipSel | input | 1 | Access strobe, one access per cycle it is high |
| readNotWrite | input | 1 | 1 = read, 0 = write |
| regSel | input | 1 | 0 = status/control, 1 = data |
| dataIn | input | 8 | Write data |
| dataOut | output | 8 | Read data, 0 when not reading |
| rxLoad | input | 1 | Receiver delivers a character |
| rxByte | input | 8 | Received character |
| rxFrameErr | input | 1 | Framing error for the delivered character |
| rxParityErr | input | 1 | Parity error for the delivered character |
| txTaken | input | 1 | Transmitter has taken the holding byte |
| txByte | output | 8 | Transmit holding byte |
| txValid | output | 1 | Holding byte is waiting (transmit not empty) |
| ctsIn | input | 1 | Clear-to-send line level |
| dcdIn | input | 1 | Carrier-detect line level |
| irqN | output | 1 | Active-low interrupt |
| clockDiv | output | 2 | Clock ratio field to the bit engines |
| wordFormat | output | 3 | Word format field to the bit engines |
| rtsN | output | 1 | Request-to-send line level |
| breakOut | output | 1 | Force break on the transmit line |
| masterReset | output | 1 | Master reset code is held in control |

## Verification
Read data appears combinationally in the same cycle as the access. So the bench samples `dataOut` at the falling edge inside that access cycle. Every flag, the control fields, `txByte`/`txValid` and `irqN` are registered or derived from registers. They take their new value at the rising edge that samples the stimulus, and the bench compares them at the next falling edge. A behavioural reference model in the bench updates at each rising edge from the same inputs. Stimulus changes one time unit after that edge, and every output is compared against the model on every falling edge.

// File: rtl/serial_host_pkg.sv
package serial_host_pkg;
  localparam int DATA_W = 8;
  localparam int DIV_W = 2;
  localparam int FMT_W = 3;

  // control field positions
  localparam int CTL_DIV_LO = 0;
  localparam int CTL_FMT_LO = 2;
  localparam int CTL_MODE_LO = 5;
  localparam int CTL_RXIE = 7;

  // status bit positions
  localparam int ST_RXFULL = 0;
  localparam int ST_TXEMPTY = 1;
  localparam int ST_DCDCHG = 2;
  localparam int ST_CTS = 3;
  localparam int ST_FRAME = 4;
  localparam int ST_OVERRUN = 5;
  localparam int ST_PARITY = 6;
  localparam int ST_IRQ = 7;

  localparam logic [DIV_W-1:0] DIV_RESET_CODE = 2'b11;

  typedef enum logic [1:0] {
    MODE_RTS_LOW = 2'b00,
    MODE_TX_IRQ  = 2'b01,
    MODE_RTS_HIGH = 2'b10,
    MODE_BREAK   = 2'b11
  } lineMode_e;

  typedef struct packed {
    logic statusRd;
    logic dataRd;
    logic ctrlWr;
    logic dataWr;
  } busStrobe_t;
endpackage

// File: rtl/serial_host_ctrl.sv
module serial_host_ctrl
  import serial_host_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipSel,
  input  logic              readNotWrite,
  input  logic              regSel,
  input  logic [DATA_W-1:0] dataIn,
  output busStrobe_t        strobe,
  output logic [DIV_W-1:0]  clockDiv,
  output logic [FMT_W-1:0]  wordFormat,
  output logic              rtsN,
  output logic              breakOut,
  output logic              rxIrqEn,
  output logic              txIrqEn,
  output logic              resetHold
);
  logic [DATA_W-1:0] ctrlReg;
  lineMode_e lineMode;

  always_comb begin
    strobe.statusRd = chipSel & readNotWrite & ~regSel;
    strobe.dataRd   = chipSel & readNotWrite & regSel;
    strobe.ctrlWr   = chipSel & ~readNotWrite & ~regSel;
    strobe.dataWr   = chipSel & ~readNotWrite & regSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlReg <= '0;
    else if (strobe.ctrlWr) ctrlReg <= dataIn;
  end

  assign lineMode   = lineMode_e'(ctrlReg[CTL_MODE_LO +: 2]);
  assign clockDiv   = ctrlReg[CTL_DIV_LO +: DIV_W];
  assign wordFormat = ctrlReg[CTL_FMT_LO +: FMT_W];
  assign rxIrqEn    = ctrlReg[CTL_RXIE];
  assign txIrqEn    = (lineMode == MODE_TX_IRQ);
  assign rtsN       = (lineMode == MODE_RTS_HIGH);
  assign breakOut   = (lineMode == MODE_BREAK);
  assign resetHold  = (clockDiv == DIV_RESET_CODE);

  // R1: at most one access kind per cycle
  p_single_access_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.statusRd, strobe.dataRd, strobe.ctrlWr, strobe.dataWr}));

  // R3: a control write shows up on the field outputs on the next cycle
  p_ctrl_fields_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ctrlWr |=> (clockDiv == $past(dataIn[CTL_DIV_LO +: DIV_W]))
                      && (wordFormat == $past(dataIn[CTL_FMT_LO +: FMT_W])));
endmodule

// File: rtl/serial_host_datapath.sv
module serial_host_datapath
  import serial_host_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  busStrobe_t        strobe,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              resetHold,
  input  logic              rxIrqEn,
  input  logic              txIrqEn,
  input  logic              rxLoad,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              rxFrameErr,
  input  logic              rxParityErr,
  input  logic              txTaken,
  input  logic              ctsIn,
  input  logic              dcdIn,
  output logic [DATA_W-1:0] dataOut,
  output logic [DATA_W-1:0] txByte,
  output logic              txValid,
  output logic              irqN
);
  logic rxFull, overrun, frameErr, parityErr;
  logic txEmpty, dcdChanged, dcdArmed, dcdPrev;
  logic [DATA_W-1:0] rxData, txData, statusByte;
  logic resetWrite, holdAll, dcdFlip, irqActive, rxCause;

  assign resetWrite = strobe.ctrlWr && (dataIn[CTL_DIV_LO +: DIV_W] == DIV_RESET_CODE);
  assign holdAll    = resetHold | resetWrite;
  assign dcdFlip    = dcdIn ^ dcdPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxFull <= 1'b0; overrun <= 1'b0; frameErr <= 1'b0; parityErr <= 1'b0;
      rxData <= '0; txData <= '0; txEmpty <= 1'b1;
      dcdChanged <= 1'b0; dcdArmed <= 1'b0; dcdPrev <= 1'b0;
    end else begin
      dcdPrev <= dcdIn;
      if (holdAll) begin
        rxFull <= 1'b0; overrun <= 1'b0; frameErr <= 1'b0; parityErr <= 1'b0;
        txEmpty <= 1'b1; dcdChanged <= 1'b0; dcdArmed <= 1'b0;
      end else begin
        // receive side
        if (strobe.dataRd) begin
          rxFull <= 1'b0; overrun <= 1'b0; frameErr <= 1'b0; parityErr <= 1'b0;
        end
        if (rxLoad) begin
          if (rxFull && !strobe.dataRd) begin
            overrun <= 1'b1;
          end else begin
            rxData <= rxByte;
            rxFull <= 1'b1;
            frameErr <= rxFrameErr;
            parityErr <= rxParityErr;
          end
        end
        // carrier change: status read arms, data read clears, edge re-latches
        if (strobe.dataRd && dcdArmed) begin
          dcdChanged <= 1'b0;
          dcdArmed <= 1'b0;
        end
        if (strobe.statusRd && dcdChanged) dcdArmed <= 1'b1;
        if (dcdFlip) begin
          dcdChanged <= 1'b1;
          dcdArmed <= 1'b0;
        end
        // transmit side
        if (txTaken) txEmpty <= 1'b1;
        if (strobe.dataWr) begin
          txData <= dataIn;
          txEmpty <= 1'b0;
        end
      end
    end
  end

  assign rxCause   = rxFull | overrun | dcdChanged;
  assign irqActive = (rxIrqEn & rxCause) | (txIrqEn & txEmpty);

  always_comb begin
    statusByte = '0;
    statusByte[ST_RXFULL]  = rxFull;
    statusByte[ST_TXEMPTY] = txEmpty;
    statusByte[ST_DCDCHG]  = dcdChanged;
    statusByte[ST_CTS]     = ctsIn;
    statusByte[ST_FRAME]   = frameErr;
    statusByte[ST_OVERRUN] = overrun;
    statusByte[ST_PARITY]  = parityErr;
    statusByte[ST_IRQ]     = irqActive;
  end

  always_comb begin
    if (strobe.statusRd) dataOut = statusByte;
    else if (strobe.dataRd) dataOut = rxData;
    else dataOut = '0;
  end

  assign txByte  = txData;
  assign txValid = ~txEmpty;
  assign irqN    = ~irqActive;

  // R4: master reset leaves clean flags behind it
  p_master_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    holdAll |=> (!rxFull && !overrun && !dcdChanged && !txValid));

  // R6: a load onto a full register marks overrun and keeps the held byte
  p_overrun_keeps_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rxLoad && rxFull && !strobe.dataRd && !holdAll) |=> (overrun && $stable(rxData)));

  // R8: a transmit write always leaves a byte waiting
  p_tx_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.dataWr && !holdAll) |=> txValid);

  // R9: carrier change survives any cycle without a data read
  p_dcd_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (dcdChanged && !strobe.dataRd && !holdAll) |=> dcdChanged);

  // R10: no interrupt without an enabled source
  p_irq_needs_enable_r10: assert property (@(posedge clk) disable iff (!rstN)
    !irqN |-> (rxIrqEn || txIrqEn));
endmodule

// File: rtl/serial_host_if.sv
module serial_host_if
  import serial_host_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipSel,
  input  logic              readNotWrite,
  input  logic              regSel,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  input  logic              rxLoad,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              rxFrameErr,
  input  logic              rxParityErr,
  input  logic              txTaken,
  output logic [DATA_W-1:0] txByte,
  output logic              txValid,
  input  logic              ctsIn,
  input  logic              dcdIn,
  output logic              irqN,
  output logic [DIV_W-1:0]  clockDiv,
  output logic [FMT_W-1:0]  wordFormat,
  output logic              rtsN,
  output logic              breakOut,
  output logic              masterReset
);
  busStrobe_t strobe;
  logic rxIrqEn, txIrqEn, resetHold;

  serial_host_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .chipSel(chipSel), .readNotWrite(readNotWrite),
    .regSel(regSel), .dataIn(dataIn), .strobe(strobe), .clockDiv(clockDiv),
    .wordFormat(wordFormat), .rtsN(rtsN), .breakOut(breakOut),
    .rxIrqEn(rxIrqEn), .txIrqEn(txIrqEn), .resetHold(resetHold)
  );

  serial_host_datapath uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dataIn(dataIn),
    .resetHold(resetHold), .rxIrqEn(rxIrqEn), .txIrqEn(txIrqEn),
    .rxLoad(rxLoad), .rxByte(rxByte), .rxFrameErr(rxFrameErr),
    .rxParityErr(rxParityErr), .txTaken(txTaken), .ctsIn(ctsIn), .dcdIn(dcdIn),
    .dataOut(dataOut), .txByte(txByte), .txValid(txValid), .irqN(irqN)
  );

  assign masterReset = resetHold;
endmodule

// File: tb/serial_host_if_test.sv
module serial_host_if_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic chipSel = 0, readNotWrite = 0, regSel = 0;
  logic [7:0] dataIn = 0, rxByte = 0;
  logic rxLoad = 0, rxFrameErr = 0, rxParityErr = 0, txTaken = 0, ctsIn = 0, dcdIn = 0;
  logic [7:0] dataOut, txByte;
  logic txValid, irqN, rtsN, breakOut, masterReset;
  logic [1:0] clockDiv;
  logic [2:0] wordFormat;

  int testCount = 0, failCount = 0;
  string curReq = "R11";
  bit done = 0;

  serial_host_if uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model state
  logic [7:0] mCtrl, mRxData, mTxData;
  logic mFull, mOvr, mFe, mPe, mTdre, mDcdChg, mArmed, mDcdPrev;

  always @(posedge clk) begin
    logic sRd, dRd, cWr, dWr, hold, flip;
    if (!rstN) begin
      mCtrl = 0; mRxData = 0; mTxData = 0; mFull = 0; mOvr = 0; mFe = 0; mPe = 0;
      mTdre = 1; mDcdChg = 0; mArmed = 0; mDcdPrev = 0;
    end else begin
      sRd = chipSel && readNotWrite && !regSel;
      dRd = chipSel && readNotWrite && regSel;
      cWr = chipSel && !readNotWrite && !regSel;
      dWr = chipSel && !readNotWrite && regSel;
      hold = (mCtrl[1:0] == 2'b11) || (cWr && dataIn[1:0] == 2'b11);
      flip = (dcdIn != mDcdPrev);
      mDcdPrev = dcdIn;
      if (cWr) mCtrl = dataIn;
      if (hold) begin
        mFull = 0; mOvr = 0; mFe = 0; mPe = 0; mTdre = 1; mDcdChg = 0; mArmed = 0;
      end else begin
        if (dRd) begin mFull = 0; mOvr = 0; mFe = 0; mPe = 0; end
        if (rxLoad) begin
          if (mFull) mOvr = 1;
          else begin mRxData = rxByte; mFull = 1; mFe = rxFrameErr; mPe = rxParityErr; end
        end
        if (dRd && mArmed) begin mDcdChg = 0; mArmed = 0; end
        if (sRd && mDcdChg) mArmed = 1;
        if (flip) begin mDcdChg = 1; mArmed = 0; end
        if (txTaken) mTdre = 1;
        if (dWr) begin mTxData = dataIn; mTdre = 0; end
      end
    end
  end

  function automatic logic modelIrq();
    return (mCtrl[7] && (mFull || mOvr || mDcdChg)) || (mCtrl[6:5] == 2'b01 && mTdre);
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s (%s) at %0t: actual %h expected %h", tag, curReq, $time, act, exp);
    end
  endtask

  // compare every output against the model away from the rising edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk({7'd0, irqN}, {7'd0, !modelIrq()}, "R10 irqN");
      chk({7'd0, txValid}, {7'd0, !mTdre}, "R8 txValid");
      chk(txByte, mTxData, "R8 txByte");
      chk({6'd0, clockDiv}, {6'd0, mCtrl[1:0]}, "R3 clockDiv");
      chk({5'd0, wordFormat}, {5'd0, mCtrl[4:2]}, "R3 wordFormat");
      chk({7'd0, rtsN}, {7'd0, mCtrl[6:5] == 2'b10}, "R3 rtsN");
      chk({7'd0, breakOut}, {7'd0, mCtrl[6:5] == 2'b11}, "R3 breakOut");
      chk({7'd0, masterReset}, {7'd0, mCtrl[1:0] == 2'b11}, "R4 masterReset");
      if (chipSel && readNotWrite && !regSel)
        chk(dataOut, {modelIrq(), mPe, mOvr, mFe, ctsIn, mDcdChg, mTdre, mFull}, "R2 status");
      else if (chipSel && readNotWrite && regSel)
        chk(dataOut, mRxData, "R5 rxData");
      else
        chk(dataOut, 8'h00, "R1 idle bus");
    end
  end

  task automatic step(input logic cs, input logic rw, input logic rs, input logic [7:0] d,
                      input logic rl, input logic [7:0] rb, input logic fe, input logic pe,
                      input logic tt);
    chipSel = cs; readNotWrite = rw; regSel = rs; dataIn = d;
    rxLoad = rl; rxByte = rb; rxFrameErr = fe; rxParityErr = pe; txTaken = tt;
    @(posedge clk); #1;
    chipSel = 0; readNotWrite = 0; regSel = 0; dataIn = 0;
    rxLoad = 0; rxFrameErr = 0; rxParityErr = 0; txTaken = 0;
  endtask

  task automatic rd(input logic rs);
    step(1, 1, rs, 8'h00, 0, 8'h00, 0, 0, 0);
  endtask
  task automatic wr(input logic rs, input logic [7:0] d);
    step(1, 0, rs, d, 0, 8'h00, 0, 0, 0);
  endtask
  task automatic rxIn(input logic [7:0] b, input logic fe, input logic pe);
    step(0, 0, 0, 8'h00, 1, b, fe, pe, 0);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 8'h00, 0, 8'h00, 0, 0, 0);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      testCount++; failCount++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #1 rstN = 1;
    curReq = "R11"; idle(2); rd(0);
    curReq = "R1"; rd(1); wr(0, 8'h08); idle(1);
    curReq = "R3"; wr(0, 8'h95); idle(1);
    curReq = "R5"; rxIn(8'h5A, 0, 1); rd(0);
    curReq = "R12"; wr(0, 8'h95); rd(0); rd(0);
    curReq = "R7"; rd(1); rd(0);
    curReq = "R6"; rxIn(8'h11, 1, 0); rxIn(8'h22, 0, 0); rxIn(8'h33, 0, 1); rd(0); rd(1); rd(0);
    curReq = "R7"; rxIn(8'h44, 0, 0); step(1, 1, 1, 8'h00, 1, 8'h55, 1, 0, 0); rd(0); rd(1); rd(0);
    curReq = "R9"; dcdIn = 1; idle(1); rd(1); rd(0); rd(1); rd(0);
    dcdIn = 0; idle(1); rd(0); dcdIn = 1; idle(1); rd(1); rd(0); rd(1); rd(0);
    curReq = "R10"; wr(0, 8'h35); idle(1); wr(1, 8'hC3); idle(1);
    step(0, 0, 0, 8'h00, 0, 8'h00, 0, 0, 1); wr(0, 8'h15); idle(1);
    curReq = "R8"; step(1, 0, 1, 8'hA7, 0, 8'h00, 0, 0, 1); idle(1);
    step(0, 0, 0, 8'h00, 0, 8'h00, 0, 0, 1); wr(1, 8'h3C); wr(1, 8'h3D); idle(1);
    curReq = "R3"; wr(0, 8'h55); idle(1); wr(0, 8'h75); idle(1); wr(0, 8'h15);
    curReq = "R4"; rxIn(8'h66, 1, 1); dcdIn = 0; wr(1, 8'h99); idle(1);
    wr(0, 8'hB7); rxIn(8'h77, 0, 0); dcdIn = 1; wr(1, 8'h88); rd(0); rd(1);
    wr(0, 8'h95); rd(0); rd(1);
    curReq = "R2"; ctsIn = 1; idle(1); rd(0); ctsIn = 0; idle(1); rd(0);
    idle(2);
    done = 1;
    summary();
    $finish;
  end
endmodule